// File: doc/BRIEF.md
# Grouped-Autoincrement Port Register Bank

This block is the register store that sits behind a two-wire serial slave controlling a bank of general-purpose pins. A byte-level front end, which is not part of this block, handles bit timing, start and stop detection and acknowledge generation. It hands this block four kinds of events:

- an address-match pulse that carries the transfer direction,
- each byte received in a write,
- an acknowledge pulse for each byte the master accepted in a read,
- a stop pulse.

In a write, the first received byte is a command. The block keeps the command as a register pointer. Each data byte that follows goes to the register the pointer selects, and the pointer then steps to the next register of the same three-register family. After the last member of a family it returns to the first member, so it never leaves the family the command chose. A read returns the register under the pointer and steps the pointer the same way on each acknowledge.

The twelve registers form four families of three, one register per 8-bit pin port:

| Family | Register numbers | Content |
|---|---|---|
| Sensed pin levels | 0–2 | read-only |
| Drive levels | 4–6 | |
| Readback inversion masks | 8–10 | |
| Direction masks | 12–14 | |

The block also drives the pin output enables and output levels from the drive and direction registers.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the drive registers (4–6) and the direction registers (12–14) read 0xFF, and the inversion registers (8–10) read 0x00. In this state `pin_oe` and `pin_out` are all zero.
- R2: After an address pulse with `addr_rnw`=0, the first `wr_valid` byte becomes the register pointer. That byte changes no register.
- R3: Each later write byte is stored in the register the pointer selects. The pointer then advances inside its family: from n*4+0 to n*4+1, from n*4+1 to n*4+2, and from n*4+2 back to n*4+0 (for example 6 is followed by 4).
- R4: A write may carry any number of data bytes. A run longer than three bytes wraps repeatedly, and the last byte written to each register is the one kept.
- R5: Data bytes aimed at registers 0–2 change nothing, but the pointer still advances with the wrap rule.
- R6: A pointer value is invalid when it is 16 or above, or when its low two bits are 3. Data sent to an invalid pointer is discarded, the pointer does not move, and a read there returns 0x00.
- R7: `rd_data` shows the register under the pointer. For registers 0–2 it shows port k of `pin_in` (bits 8k+7..8k) XOR inversion register 8+k.
- R8: After an address pulse with `addr_rnw`=1 the pointer keeps the value it had before. Each `rd_ack` advances it with the R3 wrap rule.
- R9: Bit 8k+j of `pin_oe` is the inverse of bit j of direction register 12+k (1 = input). `pin_out` carries bit j of drive register 4+k where `pin_oe` is set, and 0 elsewhere.
- R10: `wr_valid` has no effect outside a write transaction, that is when idle or during a read. A `stop` pulse ends any transaction. `rd_ack` has no effect outside a read.
- R11: Pulling `rst_n` low in the middle of a transaction restores all registers to the R1 values and leaves the block idle, so later bytes that arrive without an address pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | One-cycle pulse: this slave was addressed |
| addr_rnw | input | 1 | Direction for `addr_valid`: 1 = read, 0 = write |
| wr_valid | input | 1 | One-cycle pulse: a byte was received |
| wr_byte | input | 8 | Received byte |
| rd_ack | input | 1 | One-cycle pulse: the master acknowledged a read byte |
| stop | input | 1 | One-cycle pulse: the transaction ended |
| rd_data | output | 8 | Byte the front end will send next |
| pin_in | input | 24 | Sensed pin levels |
| pin_oe | output | 24 | Pin output enables (1 = drive) |
| pin_out | output | 24 | Pin output levels |

## Verification
The hardest behaviour to reach from the ports is wrapping inside a family. It only appears when a write or read run crosses a family's last member, and it has to be shown for every start position in every family. The bench therefore starts five-byte writes and four-byte reads at each of the nine writable registers and checks every stored value and every returned byte against a model that applies the wrap rule with its own arithmetic. Discarded data (bytes aimed at the sensed-level family, bytes sent to invalid pointers, stray bytes sent outside a write) is checked by reading all twelve registers back and comparing the pin outputs.

// File: rtl/gre_pkg.sv
package gre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_WDATA = 2'd2,
    ST_READ  = 2'd3
  } xfer_st_t;

  // Family numbers held in pointer bits [3:2].
  localparam logic [1:0] FAM_SENSE = 2'd0;
  localparam logic [1:0] FAM_DRIVE = 2'd1;
  localparam logic [1:0] FAM_INV   = 2'd2;
  localparam logic [1:0] FAM_DIR   = 2'd3;

  // A pointer names a real register only when it is below 16 and its
  // member index does not pass the last member of the family.
  function automatic logic ptr_ok(input logic [7:0] p, input logic [1:0] last);
    return (p[7:4] == 4'd0) && (p[1:0] <= last);
  endfunction

  // Step within the family; the member after the last one is member 0.
  // An invalid pointer stays where it is.
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input logic [1:0] last);
    logic [7:0] nxt;
    if (!ptr_ok(p, last))     nxt = p;
    else if (p[1:0] == last)  nxt = {p[7:2], 2'b00};
    else                      nxt = p + 8'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gre_xfer.sv
module gre_xfer
  import gre_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      addr_valid,
  input  logic      addr_rnw,
  input  logic      wr_valid,
  input  logic [7:0] wr_byte,
  input  logic      rd_ack,
  input  logic      stop,
  output xfer_st_t  st,
  output logic [7:0] ptr,
  output logic      cmd_fire,
  output logic      ptr_adv,
  output logic      store_we
);
  localparam logic [1:0] LAST = 2'(NPORT - 1);

  logic quiet;
  logic data_fire;
  logic rd_fire;

  // A new address or a stop takes priority over any byte in the same cycle.
  assign quiet     = !addr_valid && !stop;
  assign cmd_fire  = quiet && wr_valid && (st == ST_CMD);
  assign data_fire = quiet && wr_valid && (st == ST_WDATA);
  assign rd_fire   = quiet && rd_ack   && (st == ST_READ);
  assign ptr_adv   = data_fire || rd_fire;
  assign store_we  = data_fire && ptr_ok(ptr, LAST) && (ptr[3:2] != FAM_SENSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ptr <= 8'd0;
    end else begin
      if (stop)            st <= ST_IDLE;
      else if (addr_valid) st <= addr_rnw ? ST_READ : ST_CMD;
      else if (cmd_fire)   st <= ST_WDATA;

      if (cmd_fire)        ptr <= wr_byte;
      else if (ptr_adv)    ptr <= ptr_step(ptr, LAST);
    end
  end
endmodule

// File: rtl/gre_regs.sv
module gre_regs
  import gre_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int PW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [3:0]         widx,
  input  logic [PW-1:0]      wdata,
  output logic [NPORT*PW-1:0] drv_q,
  output logic [NPORT*PW-1:0] inv_q,
  output logic [NPORT*PW-1:0] dir_q
);
  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic hit;
    assign hit = we && (widx[1:0] == 2'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_q[k*PW +: PW] <= '1;
        inv_q[k*PW +: PW] <= '0;
        dir_q[k*PW +: PW] <= '1;
      end else if (hit) begin
        case (widx[3:2])
          FAM_DRIVE: drv_q[k*PW +: PW] <= wdata;
          FAM_INV:   inv_q[k*PW +: PW] <= wdata;
          FAM_DIR:   dir_q[k*PW +: PW] <= wdata;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gre_rdmux.sv
module gre_rdmux
  import gre_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int PW    = 8
) (
  input  logic [7:0]          ptr,
  input  logic [NPORT*PW-1:0] pin_in,
  input  logic [NPORT*PW-1:0] drv_q,
  input  logic [NPORT*PW-1:0] inv_q,
  input  logic [NPORT*PW-1:0] dir_q,
  output logic [PW-1:0]       rd_data
);
  localparam logic [1:0] LAST = 2'(NPORT - 1);

  logic [PW-1:0] sense_b [NPORT];
  logic [PW-1:0] drv_b   [NPORT];
  logic [PW-1:0] inv_b   [NPORT];
  logic [PW-1:0] dir_b   [NPORT];

  for (genvar k = 0; k < NPORT; k++) begin : g_slice
    assign sense_b[k] = pin_in[k*PW +: PW] ^ inv_q[k*PW +: PW];
    assign drv_b[k]   = drv_q[k*PW +: PW];
    assign inv_b[k]   = inv_q[k*PW +: PW];
    assign dir_b[k]   = dir_q[k*PW +: PW];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (ptr_ok(ptr, LAST) && (ptr[1:0] == 2'(k))) begin
        case (ptr[3:2])
          FAM_SENSE: rd_data = sense_b[k];
          FAM_DRIVE: rd_data = drv_b[k];
          FAM_INV:   rd_data = inv_b[k];
          default:   rd_data = dir_b[k];
        endcase
      end
    end
  end
endmodule

// File: rtl/gre_pins.sv
module gre_pins #(
  parameter int NBIT = 24
) (
  input  logic [NBIT-1:0] drv_q,
  input  logic [NBIT-1:0] dir_q,
  output logic [NBIT-1:0] pin_oe,
  output logic [NBIT-1:0] pin_out
);
  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    assign pin_oe[b]  = !dir_q[b];
    assign pin_out[b] = !dir_q[b] && drv_q[b];
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gre_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int PW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  input  logic                addr_rnw,
  input  logic                wr_valid,
  input  logic [7:0]          wr_byte,
  input  logic                rd_ack,
  input  logic                stop,
  output logic [PW-1:0]       rd_data,
  input  logic [NPORT*PW-1:0] pin_in,
  output logic [NPORT*PW-1:0] pin_oe,
  output logic [NPORT*PW-1:0] pin_out
);
  localparam int NBIT = NPORT * PW;

  xfer_st_t        st;
  logic [7:0]      ptr;
  logic            cmd_fire;
  logic            ptr_adv;
  logic            store_we;
  logic [NBIT-1:0] drv_q;
  logic [NBIT-1:0] inv_q;
  logic [NBIT-1:0] dir_q;

  gre_xfer #(.NPORT(NPORT)) u_xfer (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_rnw(addr_rnw),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_ack(rd_ack), .stop(stop),
    .st(st), .ptr(ptr), .cmd_fire(cmd_fire), .ptr_adv(ptr_adv),
    .store_we(store_we)
  );

  gre_regs #(.NPORT(NPORT), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(store_we), .widx(ptr[3:0]),
    .wdata(wr_byte[PW-1:0]), .drv_q(drv_q), .inv_q(inv_q), .dir_q(dir_q)
  );

  gre_rdmux #(.NPORT(NPORT), .PW(PW)) u_rdmux (
    .ptr(ptr), .pin_in(pin_in), .drv_q(drv_q), .inv_q(inv_q), .dir_q(dir_q),
    .rd_data(rd_data)
  );

  gre_pins #(.NBIT(NBIT)) u_pins (
    .drv_q(drv_q), .dir_q(dir_q), .pin_oe(pin_oe), .pin_out(pin_out)
  );
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gre_pkg::*;
#(
  parameter int NBIT  = 24,
  parameter int NPORT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input xfer_st_t        st,
  input logic [7:0]      ptr,
  input logic [7:0]      wr_byte,
  input logic            cmd_fire,
  input logic            ptr_adv,
  input logic            store_we,
  input logic [NBIT-1:0] pin_oe,
  input logic [NBIT-1:0] pin_out
);
  localparam logic [1:0] LAST = 2'(NPORT - 1);

  // R2
  cmd_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (ptr == $past(wr_byte)));

  // R3
  fam_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr_ok(ptr, LAST)) |=> ((ptr[7:2] == $past(ptr[7:2])) && (ptr[1:0] <= LAST)));

  // R6
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && !ptr_ok(ptr, LAST)) |=> $stable(ptr));

  // R5
  sense_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (ptr[3:2] != FAM_SENSE));

  // R9
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!store_we && !ptr_adv && !cmd_fire));
endmodule

bind gpio_regbank gpio_regbank_chk #(.NBIT(NPORT*PW), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ptr(ptr), .wr_byte(wr_byte),
  .cmd_fire(cmd_fire), .ptr_adv(ptr_adv), .store_we(store_we),
  .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/tb_gpio_regbank.sv
`timescale 1ns/1ps
module tb_gpio_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic        addr_rnw = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_byte = 8'd0;
  logic        rd_ack = 1'b0;
  logic        stop = 1'b0;
  logic [7:0]  rd_data;
  logic [23:0] pin_in = 24'd0;
  logic [23:0] pin_oe;
  logic [23:0] pin_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] mdl [16];
  logic [7:0] mptr;

  always #10 clk = ~clk;

  gpio_regbank dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_rnw(addr_rnw),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_ack(rd_ack), .stop(stop),
    .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic bit b_ok(input logic [7:0] p);
    return (p < 8'd16) && ((p % 4) != 3);
  endfunction

  function automatic logic [7:0] b_next(input logic [7:0] p);
    if (!b_ok(p)) return p;
    return 8'((p / 4) * 4 + ((p % 4) + 1) % 3);
  endfunction

  function automatic logic [7:0] b_read(input logic [7:0] p);
    if (!b_ok(p)) return 8'h00;
    if (p < 4) return pin_in[(p % 4) * 8 +: 8] ^ mdl[8 + p % 4];
    return mdl[p];
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    for (int i = 4; i < 7; i++) mdl[i] = 8'hFF;
    for (int i = 12; i < 15; i++) mdl[i] = 8'hFF;
    mptr = 8'd0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_addr(input bit rnw);
    addr_valid = 1'b1; addr_rnw = rnw;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] b);
    wr_valid = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic set_cmd(input logic [7:0] c);
    pulse_addr(1'b0);
    pulse_byte(c);
    pulse_stop();
    mptr = c;
  endtask

  // Write cmd then n bytes of a seeded pattern, updating the model.
  task automatic wr_run(input logic [7:0] c, input int n, input int seed);
    pulse_addr(1'b0);
    pulse_byte(c);
    mptr = c;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = 8'((seed * 37 + k * 53 + 11) ^ 8'h5A);
      pulse_byte(v);
      if (b_ok(mptr) && mptr >= 4) mdl[mptr] = v;
      mptr = b_next(mptr);
    end
    pulse_stop();
  endtask

  task automatic rd_run(input int n, input string req);
    pulse_addr(1'b1);
    for (int k = 0; k < n; k++) begin
      chk(req, 32'(rd_data), 32'(b_read(mptr)));
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      mptr = b_next(mptr);
    end
    pulse_stop();
  endtask

  task automatic chk_pins(input string req);
    logic [23:0] eoe, eout;
    for (int k = 0; k < 3; k++) begin
      eoe[k*8 +: 8]  = ~mdl[12 + k];
      eout[k*8 +: 8] = ~mdl[12 + k] & mdl[4 + k];
    end
    chk(req, 32'(pin_oe), 32'(eoe));
    chk(req, 32'(pin_out), 32'(eout));
  endtask

  task automatic dump_all(input string req);
    for (int f = 0; f < 4; f++) begin
      set_cmd(8'(f * 4));
      rd_run(3, req);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(pin_oe), 32'd0);
    chk("R1 out", 32'(pin_out), 32'd0);
    dump_all("R1 defaults");

    // R2 command alone changes nothing
    set_cmd(8'd5);
    dump_all("R2 cmd only");

    // R3 R4 R8 R9 sweep over every writable start register
    for (int f = 1; f < 4; f++) begin
      for (int s = 0; s < 3; s++) begin
        wr_run(8'(f * 4 + s), 5, f * 3 + s);
        set_cmd(8'(f * 4 + s));
        rd_run(4, "R3 R4 R8 wrap run");
        chk_pins("R9 pins");
      end
    end

    // R3 explicit: write at 6, next byte lands in 4
    pulse_addr(1'b0); pulse_byte(8'd6); pulse_byte(8'h3C); pulse_byte(8'hC3); pulse_stop();
    mdl[6] = 8'h3C; mdl[4] = 8'hC3;
    set_cmd(8'd4); rd_run(1, "R3 6 then 4");
    set_cmd(8'd6); rd_run(1, "R3 6 then 4");
    chk_pins("R9 after wrap");

    // R5 writes to sensed family ignored, pointer still advances
    pin_in = 24'h00_00_00;
    wr_run(8'd1, 4, 99);
    rd_run(3, "R5 ptr after sense write");
    dump_all("R5 sense write ignored");

    // R7 sensed readback with inversion, several patterns
    for (int p = 0; p < 6; p++) begin
      pin_in = 24'((p * 24'h3A5C1) ^ 24'hF0_0F_A5);
      wr_run(8'd8, 3, p + 40);
      set_cmd(8'd0);
      rd_run(4, "R7 sense xor inv");
    end

    // R6 invalid pointers
    begin
      logic [7:0] bad [6] = '{8'd3, 8'd7, 8'd11, 8'd15, 8'h20, 8'h84};
      for (int i = 0; i < 6; i++) begin
        wr_run(bad[i], 2, 70 + i);
        set_cmd(bad[i]);
        rd_run(2, "R6 invalid reads zero");
      end
    end
    dump_all("R6 invalid write ignored");

    // R10 stray bytes outside a write
    pulse_byte(8'h00);
    pulse_byte(8'h11);
    pulse_addr(1'b1);
    pulse_byte(8'h0C);
    pulse_byte(8'h00);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    mptr = b_next(mptr);
    pulse_stop();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    pulse_byte(8'h22);
    chk_pins("R10 pins unchanged");
    dump_all("R10 stray ignored");

    // R11 reset mid-transaction
    pulse_addr(1'b0); pulse_byte(8'd12); pulse_byte(8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
    @(negedge clk);
    pulse_byte(8'h00);
    pulse_byte(8'h00);
    chk("R11 oe", 32'(pin_oe), 32'd0);
    chk("R11 out", 32'(pin_out), 32'd0);
    dump_all("R11 defaults after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule